// File: doc/BRIEF.md
# Scanline Video Memory Slot Scheduler

This block decides, for every memory access window of a scanline, what the video memory does in that window. There are 171 windows per line, one for every two internal pixel clocks. Each window carries one of four access kinds: a background name fetch, a pattern fetch, a sprite Y-coordinate fetch, or an external slot that the processor may use. Windows that the active schedule leaves unused are marked as refresh or idle. The result also carries a column number for name and pattern fetches, or a sprite number for sprite fetches. Address generation and the data path are handled elsewhere.

There are three schedules. A blanked line uses a refresh layout. Text mode uses a layout of 40 three-slot groups. Character mode uses a layout of 32 four-slot blocks that interleaves sprite fetches with external slots. The requested mode, the blank request and the sprite enable are captured once per line, in the window whose index is the `LATCH_SLOT` parameter (default 0). The captured values apply from that window until the next capture. The window timing comes from a strobe that carries the window index. The decoded result is registered and appears one clock after the strobe.

Top module: `vram_slot_sched`

## Requirements
- R1: Each strobed window produces `slot_vld`=1 and its decoded result exactly one clock later. A clock with no strobe produces `slot_vld`=0, `slot_kind`=0, `slot_refresh`=0 and `slot_col`=0 one clock later. The kind encoding is 00 external, 01 name, 10 pattern, 11 sprite.
- R2: Out of reset, outputs are zero and the held line setup is "blanked". Every window before the first capture window is decoded with the refresh layout, whatever the requests are.
- R3: Refresh layout. A window is external when its index is below 26, is odd, or is 154 or more. Every other window reports kind 00 with `slot_refresh`=1 and column 0.
- R4: Text layout. Windows below 30 and windows from 150 up are external. Windows 30 to 149 form groups of three: name, external, pattern. The group number (index−30)/3, from 0 to 39, is the column of the name and pattern fetches.
- R5: Character layout. Windows 0–4, 15–18, 155 and 156 are external. Windows 27 to 154 form 32 blocks of four, with block b = (index−27)/4. Slot 0 of a block is a name fetch, slots 2 and 3 are pattern fetches, and each of these uses column b.
- R6: In character layout with sprites enabled, slot 1 of block b is external when b mod 4 = 0. Otherwise it is a sprite fetch with sprite number 8 + 3·(b div 4) + (b mod 4) − 1.
- R7: In character layout with sprites disabled, every slot 1 of a block is external.
- R8: In character layout, the windows 5–14, 19–26 and 157–170 are reported as refresh/idle: kind 00, `slot_refresh`=1, column 0.
- R9: The requests are captured in the strobed window whose index equals `LATCH_SLOT`. That same window is already decoded with the new values. Request changes at any other time have no effect until the next capture.
- R10: A captured blank request selects the refresh layout, whatever mode is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_strobe | input | 1 | Marks a memory access window in this clock |
| slot_idx | input | IDX_W | Index of the window within the line, 0..170 |
| mode_text | input | 1 | Mode request: 1 selects text, 0 selects character |
| blank_req | input | 1 | Blank request: 1 selects the refresh layout |
| sprite_req | input | 1 | Sprite fetch enable for the character layout |
| slot_vld | output | 1 | Registered result is valid |
| slot_kind | output | 2 | Access kind: 00 external, 01 name, 10 pattern, 11 sprite |
| slot_refresh | output | 1 | Window is refresh/idle (kind is 00) |
| slot_col | output | 6 | Column (name/pattern) or sprite number (sprite) |

## Verification
The capture of the line setup and the decode of a window can fall in the same clock. This happens at the capture window, which must already be decoded with the freshly requested setup and not with the one held from the previous line. The bench changes the requests in the clock that carries window 0. It also changes them again in the middle of lines, including a switch into and out of blanking. A behavioural reference that keeps its own held setup then judges every output clock, so a design that applies the capture one window late, or that lets a mid-line change through, shows a mismatch in that very window.

// File: rtl/vsched_pkg.sv
package vsched_pkg;

    localparam int LINE_SLOTS   = 171;
    localparam int COL_W        = 6;

    // refresh layout boundaries
    localparam int REF_FIRST    = 26;
    localparam int REF_END      = 154;

    // text layout boundaries
    localparam int TXT_FIRST    = 30;
    localparam int TXT_END      = 150;
    localparam int TXT_GROUPS   = 40;

    // character layout boundaries
    localparam int CHR_EXT_A_END = 5;
    localparam int CHR_EXT_B_LO  = 15;
    localparam int CHR_EXT_B_HI  = 18;
    localparam int CHR_EXT_C_LO  = 155;
    localparam int CHR_EXT_C_HI  = 156;
    localparam int CHR_BLK_FIRST = 27;
    localparam int CHR_BLOCKS    = 32;
    localparam int CHR_BLK_END   = CHR_BLK_FIRST + 4 * CHR_BLOCKS;
    localparam int SPR_BASE      = 8;

    typedef enum logic [1:0] {
        K_EXT  = 2'b00,
        K_NAME = 2'b01,
        K_PAT  = 2'b10,
        K_SPR  = 2'b11
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e             kind;
        logic                   refresh;
        logic [COL_W-1:0]       col;
    } slot_res_t;

    typedef struct packed {
        logic blank;
        logic text;
        logic spr;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{blank: 1'b1, text: 1'b0, spr: 1'b0};
    localparam slot_res_t RES_NONE  = '{kind: K_EXT, refresh: 1'b0, col: '0};

    function automatic slot_res_t res_make(slot_kind_e k, logic r, logic [COL_W-1:0] c);
        slot_res_t v;
        v.kind    = k;
        v.refresh = r;
        v.col     = c;
        return v;
    endfunction

endpackage

// File: rtl/vsched_mode_latch.sv
module vsched_mode_latch
    import vsched_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int LATCH_SLOT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [IDX_W-1:0] idx,
    input  line_cfg_t        req,
    output line_cfg_t        cfg_now,
    output line_cfg_t        cfg_held,
    output logic             hit
);
    localparam logic [IDX_W-1:0] LATCH_IDX = IDX_W'(LATCH_SLOT);

    line_cfg_t held_q;

    assign hit      = strobe && (idx == LATCH_IDX);
    // the capture window already runs with the new setup
    assign cfg_now  = hit ? req : held_q;
    assign cfg_held = held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= CFG_RESET;
        end else if (hit) begin
            held_q <= req;
        end
    end
endmodule

// File: rtl/vsched_refresh_dec.sv
module vsched_refresh_dec
    import vsched_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output slot_res_t        res
);
    logic ext;

    always_comb begin
        ext = (idx < IDX_W'(REF_FIRST)) || idx[0] || (idx >= IDX_W'(REF_END));
        if (ext) begin
            res = res_make(K_EXT, 1'b0, '0);
        end else begin
            res = res_make(K_EXT, 1'b1, '0);
        end
    end
endmodule

// File: rtl/vsched_text_dec.sv
module vsched_text_dec
    import vsched_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output slot_res_t        res
);
    logic [IDX_W-1:0] off;
    logic [IDX_W-1:0] grp;
    logic [IDX_W-1:0] phase;

    always_comb begin
        off   = idx - IDX_W'(TXT_FIRST);
        grp   = off / IDX_W'(3);
        phase = off - (grp + grp + grp);
        if ((idx < IDX_W'(TXT_FIRST)) || (idx >= IDX_W'(TXT_END))) begin
            res = res_make(K_EXT, 1'b0, '0);
        end else begin
            unique case (phase[1:0])
                2'd0:    res = res_make(K_NAME, 1'b0, grp[COL_W-1:0]);
                2'd2:    res = res_make(K_PAT,  1'b0, grp[COL_W-1:0]);
                default: res = res_make(K_EXT,  1'b0, '0);
            endcase
        end
    end
endmodule

// File: rtl/vsched_char_dec.sv
module vsched_char_dec
    import vsched_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             spr_en,
    output slot_res_t        res
);
    logic             fixed_ext;
    logic             in_blocks;
    logic [IDX_W-1:0] off;
    logic [4:0]       blk;
    logic [COL_W-1:0] spr_num;
    logic [COL_W-1:0] blk_col;

    always_comb begin
        fixed_ext = (idx < IDX_W'(CHR_EXT_A_END))
                 || ((idx >= IDX_W'(CHR_EXT_B_LO)) && (idx <= IDX_W'(CHR_EXT_B_HI)))
                 || ((idx >= IDX_W'(CHR_EXT_C_LO)) && (idx <= IDX_W'(CHR_EXT_C_HI)));
        in_blocks = (idx >= IDX_W'(CHR_BLK_FIRST)) && (idx < IDX_W'(CHR_BLK_END));
        off       = idx - IDX_W'(CHR_BLK_FIRST);
        blk       = off[6:2];
        blk_col   = {1'b0, blk};
        // 8 + 3*(blk div 4) + (blk mod 4) - 1
        spr_num   = COL_W'(SPR_BASE) + {1'b0, blk[4:2], 2'b00} - {3'b000, blk[4:2]}
                  + {4'b0000, blk[1:0]} - COL_W'(1);

        if (fixed_ext) begin
            res = res_make(K_EXT, 1'b0, '0);
        end else if (in_blocks) begin
            unique case (off[1:0])
                2'd0: res = res_make(K_NAME, 1'b0, blk_col);
                2'd1: begin
                    if ((blk[1:0] == 2'd0) || !spr_en) begin
                        res = res_make(K_EXT, 1'b0, '0);
                    end else begin
                        res = res_make(K_SPR, 1'b0, spr_num);
                    end
                end
                default: res = res_make(K_PAT, 1'b0, blk_col);
            endcase
        end else begin
            res = res_make(K_EXT, 1'b1, '0);
        end
    end
endmodule

// File: rtl/vram_slot_sched.sv
module vram_slot_sched
    import vsched_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int LATCH_SLOT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_strobe,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             mode_text,
    input  logic             blank_req,
    input  logic             sprite_req,
    output logic             slot_vld,
    output logic [1:0]       slot_kind,
    output logic             slot_refresh,
    output logic [5:0]       slot_col
);
    line_cfg_t req_cfg;
    line_cfg_t cfg_now;
    line_cfg_t cfg_held;
    logic      latch_hit;
    slot_res_t res_ref;
    slot_res_t res_txt;
    slot_res_t res_chr;
    slot_res_t res_sel;
    slot_res_t res_q;
    logic      vld_q;

    assign req_cfg = '{blank: blank_req, text: mode_text, spr: sprite_req};

    vsched_mode_latch #(.IDX_W(IDX_W), .LATCH_SLOT(LATCH_SLOT)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .strobe   (slot_strobe),
        .idx      (slot_idx),
        .req      (req_cfg),
        .cfg_now  (cfg_now),
        .cfg_held (cfg_held),
        .hit      (latch_hit)
    );

    vsched_refresh_dec #(.IDX_W(IDX_W)) u_ref (.idx(slot_idx), .res(res_ref));
    vsched_text_dec    #(.IDX_W(IDX_W)) u_txt (.idx(slot_idx), .res(res_txt));
    vsched_char_dec    #(.IDX_W(IDX_W)) u_chr (.idx(slot_idx), .spr_en(cfg_now.spr), .res(res_chr));

    always_comb begin
        if (cfg_now.blank) begin
            res_sel = res_ref;
        end else if (cfg_now.text) begin
            res_sel = res_txt;
        end else begin
            res_sel = res_chr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= RES_NONE;
        end else begin
            vld_q <= slot_strobe;
            res_q <= slot_strobe ? res_sel : RES_NONE;
        end
    end

    assign slot_vld     = vld_q;
    assign slot_kind    = res_q.kind;
    assign slot_refresh = res_q.refresh;
    assign slot_col     = res_q.col;
endmodule

// File: rtl/vsched_chk.sv
module vsched_chk (
    input logic       clk,
    input logic       rst,
    input logic       slot_strobe,
    input logic       slot_vld,
    input logic [1:0] slot_kind,
    input logic       slot_refresh,
    input logic [5:0] slot_col,
    input logic       latch_hit,
    input logic [2:0] held_cfg,
    input logic [2:0] req_cfg
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |=> slot_vld);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_strobe |=> (!slot_vld && slot_kind == 2'b00 && !slot_refresh && slot_col == 6'd0));

    // R8
    refresh_kind_chk: assert property (@(posedge clk) disable iff (rst)
        slot_refresh |-> (slot_kind == 2'b00 && slot_col == 6'd0));

    // R6
    sprite_range_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && slot_kind == 2'b11) |-> (slot_col >= 6'd8 && slot_col <= 6'd31));

    // R4
    column_range_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && (slot_kind == 2'b01 || slot_kind == 2'b10)) |-> (slot_col <= 6'd39));

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_hit |=> $stable(held_cfg));

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        latch_hit |=> (held_cfg == $past(req_cfg)));
endmodule

bind vram_slot_sched vsched_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_strobe  (slot_strobe),
    .slot_vld     (slot_vld),
    .slot_kind    (slot_kind),
    .slot_refresh (slot_refresh),
    .slot_col     (slot_col),
    .latch_hit    (latch_hit),
    .held_cfg     (cfg_held),
    .req_cfg      (req_cfg)
);

// File: tb/tb_vram_slot_sched.sv
`timescale 1ns/1ps
module tb_vram_slot_sched;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_strobe = 1'b0;
    logic [7:0] slot_idx = '0;
    logic       mode_text = 1'b0;
    logic       blank_req = 1'b0;
    logic       sprite_req = 1'b0;
    logic       slot_vld;
    logic [1:0] slot_kind;
    logic       slot_refresh;
    logic [5:0] slot_col;

    always #10 clk = ~clk;

    vram_slot_sched dut (
        .clk(clk), .rst(rst), .slot_strobe(slot_strobe), .slot_idx(slot_idx),
        .mode_text(mode_text), .blank_req(blank_req), .sprite_req(sprite_req),
        .slot_vld(slot_vld), .slot_kind(slot_kind), .slot_refresh(slot_refresh),
        .slot_col(slot_col)
    );

    int checks = 0;
    int failures = 0;
    int gap_ctr = 0;

    // reference state
    bit m_blank = 1'b1;
    bit m_text  = 1'b0;
    bit m_spr   = 1'b0;
    bit m_seen  = 1'b0;
    int e_vld = 0, e_kind = 0, e_ref = 0, e_col = 0;
    string e_tag = "R2";

    task automatic model_step(bit stb, int idx, bit t, bit b, bit s);
        int blk, ph;
        bit differs;
        if (!stb) begin
            e_vld = 0; e_kind = 0; e_ref = 0; e_col = 0; e_tag = "R1";
            return;
        end
        if (idx == 0) begin
            m_blank = b; m_text = t; m_spr = s; m_seen = 1'b1;
        end
        differs = (b != m_blank) || (!m_blank && (t != m_text)) || (!m_blank && !m_text && (s != m_spr));
        e_vld = 1; e_kind = 0; e_ref = 0; e_col = 0;
        if (m_blank) begin
            e_tag = m_seen ? "R3 R10" : "R2";
            if (idx < 26 || (idx % 2) == 1 || idx >= 154) e_ref = 0;
            else e_ref = 1;
        end else if (m_text) begin
            e_tag = "R4";
            if (idx >= 30 && idx < 150) begin
                ph = (idx - 30) % 3;
                if (ph == 0) begin e_kind = 1; e_col = (idx - 30) / 3; end
                else if (ph == 2) begin e_kind = 2; e_col = (idx - 30) / 3; end
            end
        end else begin
            e_tag = "R5";
            if (idx <= 4 || (idx >= 15 && idx <= 18) || idx == 155 || idx == 156) begin
                e_kind = 0;
            end else if (idx >= 27 && idx < 155) begin
                blk = (idx - 27) / 4;
                ph  = (idx - 27) % 4;
                if (ph == 0) begin e_kind = 1; e_col = blk; end
                else if (ph == 1) begin
                    if (!m_spr) e_tag = "R7";
                    else begin
                        e_tag = "R6";
                        if (blk % 4 != 0) begin e_kind = 3; e_col = 8 + 3 * (blk / 4) + (blk % 4) - 1; end
                    end
                end else begin e_kind = 2; e_col = blk; end
            end else begin
                e_tag = "R8";
                e_ref = 1;
            end
        end
        if (differs) e_tag = {e_tag, " R9"};
    endtask

    task automatic compare();
        checks++;
        if (slot_vld !== 1'(e_vld) || slot_kind !== 2'(e_kind) ||
            slot_refresh !== 1'(e_ref) || slot_col !== 6'(e_col)) begin
            failures++;
            $display("FAIL %s: got vld=%0d kind=%0d ref=%0d col=%0d expected vld=%0d kind=%0d ref=%0d col=%0d",
                     e_tag, slot_vld, slot_kind, slot_refresh, slot_col, e_vld, e_kind, e_ref, e_col);
        end
    endtask

    task automatic tick(bit stb, int idx, bit t, bit b, bit s);
        @(negedge clk);
        compare();
        slot_strobe = stb;
        slot_idx    = 8'(idx);
        mode_text   = t;
        blank_req   = b;
        sprite_req  = s;
        model_step(stb, idx, t, b, s);
    endtask

    // one line; requests switch to the second set from window sw_at on
    task automatic run_line(int first, bit t, bit b, bit s, int sw_at, bit t2, bit b2, bit s2);
        for (int i = first; i < 171; i++) begin
            bit ct, cb, cs;
            ct = (i >= sw_at) ? t2 : t;
            cb = (i >= sw_at) ? b2 : b;
            cs = (i >= sw_at) ? s2 : s;
            gap_ctr++;
            if (gap_ctr % 5 == 4) tick(1'b0, 0, ct, cb, cs); // R1 idle clocks
            tick(1'b1, i, ct, cb, cs);
        end
    endtask

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset outputs, then a partial line before any capture
        tick(1'b0, 0, 1'b1, 1'b0, 1'b1);
        run_line(100, 1'b1, 1'b0, 1'b1, 999, 1'b0, 1'b0, 1'b0);
        // R5 R6: character with sprites
        run_line(0, 1'b0, 1'b0, 1'b1, 999, 1'b0, 1'b0, 1'b0);
        // R7: character without sprites
        run_line(0, 1'b0, 1'b0, 1'b0, 999, 1'b0, 1'b0, 1'b0);
        // R4: text
        run_line(0, 1'b1, 1'b0, 1'b0, 999, 1'b0, 1'b0, 1'b0);
        // R10: blank wins over text
        run_line(0, 1'b1, 1'b1, 1'b1, 999, 1'b0, 1'b0, 1'b0);
        // R9: character line with a mid-line request for text
        run_line(0, 1'b0, 1'b0, 1'b1, 60, 1'b1, 1'b0, 1'b0);
        // R9: text line with a mid-line blank request
        run_line(0, 1'b1, 1'b0, 1'b0, 90, 1'b1, 1'b1, 1'b0);
        // R9 R10: blanked line released mid-line
        run_line(0, 1'b0, 1'b1, 1'b1, 40, 1'b0, 1'b0, 1'b1);
        // R3: refresh again, then R6 character closing line
        run_line(0, 1'b0, 1'b1, 1'b0, 999, 1'b0, 1'b0, 1'b0);
        run_line(0, 1'b0, 1'b0, 1'b1, 999, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 0, 1'b0, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule